// File: doc/BRIEF.md
# Multi-Channel DMA Queue Control Block

This block holds the per-channel control and status state of a memory-to-memory DMA engine with several independent channels. Software reaches it over a simple 32-bit register bus. Each channel owns a 256-byte register window, and the windows are stacked so that channel n starts at byte n × 0x100. A window holds the submission and completion queue base and depth registers, the submission tail doorbell, the completion head pointer, control bits (enable, pause, self-clearing soft reset), a 4-bit channel state code, and an interrupt status register with its mask.

Each channel runs an eight-state controller. Software rings the doorbell by writing the tail pointer. The channel then issues a one-cycle start pulse to the external descriptor engine and presents the index of the entry to process. It then waits for the engine's done strobe, which carries an error flag and the descriptor's local interrupt flag. Pause stalls a running channel. Clearing enable drains the descriptor in flight and then halts. A soft reset puts the channel back to idle with cleared pointers. Descriptor fetch and data movement live outside this block.

Top module: `mcd_chan_ctl`

## Requirements
- R1: Channel n's window starts at byte address n × 0x100, and the low 8 address bits select the register. Reads return data on `bus_rdata` from the clock edge at which `bus_re` is sampled. Unmapped offsets and channel numbers of NUM_CH or more read as zero.
- R2: The queue registers read back as written: submission base low/high at 0x00/0x04 and completion base low/high at 0x10/0x14 hold 32 bits each; submission depth at 0x08 and completion depth at 0x18 hold PTR_W bits and encode the entry count minus one.
- R3: Control register 0x20 holds enable in bit 0 and pause in bit 4, and reads back both. Control register 0x24 bit 0 is the soft reset request.
- R4: An idle channel enters run on the clock edge after it is enabled, unpaused and has its tail (0x0C) differing from its internal head. `eng_start` is then high for exactly the first run cycle, and `eng_sq_idx` shows the head index.
- R5: A done strobe without error in run moves the channel to complete (code 2) and advances the head by one, wrapping from the submission depth value to zero. One cycle later the channel is back in idle.
- R6: A done strobe with error in run moves the channel to abort (code 5) without advancing the head. The channel stays in abort until a soft reset.
- R7: Setting pause while running moves the channel to pause (code 3), with `eng_hold` high. Clearing it returns the channel to run. An idle channel that is paused never starts.
- R8: Clearing enable while running moves the channel to wait (code 6). Its next done strobe moves it to halt (code 4), and the cycle after that to idle.
- R9: Writing 1 to bit 0 of 0x24 makes that bit read 1 for one cycle and then 0. The next edge puts the channel in buffer-clear (code 7), zeroes the tail, completion head and internal head, and the following edge puts it in idle.
- R10: Register 0x30 bits 3:0 report the state code: idle 0, run 1, complete 2, pause 3, halt 4, abort 5, wait 6, buffer-clear 7.
- R11: Interrupt status at 0x40 is 13 bits wide and write-one-to-clear. Bit 0 is set by a successful done with the local interrupt flag. Bit 1 is set by any done with error. A set wins over a clear in the same cycle.
- R12: Interrupt mask at 0x44 is 13 bits wide and resets to all ones. A channel's `irq` is high when any status bit is set whose mask bit is zero.
- R13: Channels are independent: a write to one channel's window changes no other channel's registers or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address: channel in the upper bits, register in the low 8 bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| eng_start | output | NUM_CH | One-cycle start request per channel |
| eng_hold | output | NUM_CH | Stall request per channel while paused |
| eng_sq_idx | output | NUM_CH*PTR_W | Submission queue index to process, per channel |
| eng_sq_base | output | NUM_CH*64 | Submission queue base address, per channel |
| eng_done | input | NUM_CH | Descriptor finished, per channel |
| eng_err | input | NUM_CH | Error flag qualifying `eng_done` |
| eng_lirq | input | NUM_CH | Local interrupt flag qualifying `eng_done` |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
A register write takes effect at the edge that samples it. A state change that the write triggers appears one edge later, and the start pulse is visible in that same following cycle. A read returns the value held just before the edge that samples `bus_re`. The bench therefore reads a transient state (complete, halt, buffer-clear) in the cycle right after its cause, and it waits one extra cycle before reading a state that a control write produces. `eng_start`, `eng_hold`, `eng_sq_idx` and `irq` are sampled at the falling edge after the cycle in which the bench has worked out they change. The bench waits for start pulses with a short bounded poll, so the random traffic does not need exact counts.

// File: rtl/mcd_pkg.sv
// Shared definitions for the multi-channel DMA queue control block.
// Assumes a 256-byte register window per channel and a 32-bit data bus.
package mcd_pkg;
    localparam int WIN_BITS = 8;
    localparam int IRQ_W    = 13;

    // Register offsets inside one channel window (software decodes these)
    localparam logic [WIN_BITS-1:0] OFS_SQB_LO = 8'h00;
    localparam logic [WIN_BITS-1:0] OFS_SQB_HI = 8'h04;
    localparam logic [WIN_BITS-1:0] OFS_SQ_DEP = 8'h08;
    localparam logic [WIN_BITS-1:0] OFS_SQ_TL  = 8'h0C;
    localparam logic [WIN_BITS-1:0] OFS_CQB_LO = 8'h10;
    localparam logic [WIN_BITS-1:0] OFS_CQB_HI = 8'h14;
    localparam logic [WIN_BITS-1:0] OFS_CQ_DEP = 8'h18;
    localparam logic [WIN_BITS-1:0] OFS_CQ_HD  = 8'h1C;
    localparam logic [WIN_BITS-1:0] OFS_CTL_A  = 8'h20;
    localparam logic [WIN_BITS-1:0] OFS_CTL_B  = 8'h24;
    localparam logic [WIN_BITS-1:0] OFS_STATE  = 8'h30;
    localparam logic [WIN_BITS-1:0] OFS_IST    = 8'h40;
    localparam logic [WIN_BITS-1:0] OFS_IMSK   = 8'h44;

    // Bit positions inside control and status registers
    localparam int BIT_EN      = 0;
    localparam int BIT_PAUSE   = 4;
    localparam int BIT_SRST    = 0;
    localparam int BIT_IST_OK  = 0;
    localparam int BIT_IST_ERR = 1;

    typedef enum logic [3:0] {
        CS_IDLE   = 4'd0,
        CS_RUN    = 4'd1,
        CS_CPL    = 4'd2,
        CS_PAUSE  = 4'd3,
        CS_HALT   = 4'd4,
        CS_ABORT  = 4'd5,
        CS_WAIT   = 4'd6,
        CS_BUFCLR = 4'd7
    } chan_state_e;
endpackage

// File: rtl/mcd_addr_dec.sv
// Shared address decoder: splits the bus address into a channel number
// (upper bits) and a register offset (low WIN_BITS bits), and produces one
// write strobe per channel. Assumes NUM_CH >= 1; out-of-range channel
// numbers produce no strobe and no read hit.
module mcd_addr_dec
    import mcd_pkg::*;
#(
    parameter  int NUM_CH  = 4,
    parameter  int CH_BITS = 2,
    localparam int ADDR_W  = WIN_BITS + CH_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    output logic [NUM_CH-1:0]   ch_we,
    output logic [WIN_BITS-1:0] offs,
    output logic [CH_BITS-1:0]  ch_num,
    output logic                hit
);
    assign offs   = addr[WIN_BITS-1:0];
    assign ch_num = addr[ADDR_W-1:WIN_BITS];
    assign hit    = (32'(ch_num) < NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        // One write strobe per channel window
        assign ch_we[g] = we && (ch_num == CH_BITS'(g));
    end
endmodule

// File: rtl/mcd_chan_fsm.sv
// Channel controller: eight coded states driven by enable, pause and a
// one-cycle soft reset request. Assumes the engine raises done only while
// the channel is in run or wait; a done strobe in any other state is ignored.
module mcd_chan_fsm
    import mcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pause,
    input  logic       soft_rst,
    input  logic       pending,
    input  logic       eng_done,
    input  logic       eng_err,
    output logic [3:0] state_o,
    output logic       start_o,
    output logic       hold_o,
    output logic       cmpl_ok,
    output logic       cmpl_err
);
    chan_state_e state_q, state_d;
    logic        go, accept, start_q;

    assign go       = en && !pause && pending;
    assign accept   = eng_done && !soft_rst && (state_q == CS_RUN || state_q == CS_WAIT);
    assign cmpl_ok  = accept && !eng_err;
    assign cmpl_err = accept && eng_err;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = CS_BUFCLR;
        end else begin
            unique case (state_q)
                CS_IDLE:   if (go) state_d = CS_RUN;
                CS_RUN: begin
                    if (eng_done)
                        state_d = eng_err ? CS_ABORT : (en ? CS_CPL : CS_HALT);
                    else if (!en)
                        state_d = CS_WAIT;
                    else if (pause)
                        state_d = CS_PAUSE;
                end
                CS_PAUSE: begin
                    if (!en)        state_d = CS_WAIT;
                    else if (!pause) state_d = CS_RUN;
                end
                CS_WAIT:   if (eng_done) state_d = CS_HALT;
                CS_CPL:    state_d = CS_IDLE;
                CS_HALT:   state_d = CS_IDLE;
                CS_ABORT:  state_d = CS_ABORT;
                CS_BUFCLR: state_d = CS_IDLE;
                default:   state_d = CS_IDLE;
            endcase
        end
    end

    // State and start-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= !soft_rst && (state_q == CS_IDLE) && go;
        end
    end

    assign state_o = state_q;
    assign start_o = start_q;
    assign hold_o  = (state_q == CS_PAUSE);

    // R4: run is only entered from idle when the start condition held
    p_run_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && $past(state_q) == CS_IDLE) |-> $past(en && !pause && pending));
    // R4: start is a single-cycle pulse
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R6: abort is left only through a soft reset
    p_abort_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_ABORT && !soft_rst) |=> state_q == CS_ABORT);
    // R7: pause stalls a running, enabled channel
    p_pause_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && en && pause && !eng_done && !soft_rst) |=> state_q == CS_PAUSE);
    // R8: halt lasts one cycle before idle
    p_halt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HALT && !soft_rst) |=> state_q == CS_IDLE);
endmodule

// File: rtl/mcd_chan_regs.sv
// One channel window: queue registers, control bits, soft reset,
// interrupt status and mask, and the channel controller. Assumes
// PTR_W <= 32. Read data is combinational from the offset; the top
// registers it.
module mcd_chan_regs
    import mcd_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WIN_BITS-1:0] offs,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_val,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic                eng_lirq,
    output logic                eng_start,
    output logic                eng_hold,
    output logic [PTR_W-1:0]    sq_idx,
    output logic [63:0]         sq_base,
    output logic                irq
);
    localparam int PAD_P = 32 - PTR_W;
    localparam int PAD_I = 32 - IRQ_W;

    logic [63:0]      sqb_q, cqb_q;
    logic [PTR_W-1:0] sq_dep_q, cq_dep_q, sq_tl_q, cq_hd_q, sq_hd_q;
    logic             en_q, pause_q, srst_q;
    logic [IRQ_W-1:0] ist_q, imsk_q, ist_set, ist_clr;
    logic [3:0]       state;
    logic             cmpl_ok, cmpl_err;

    function automatic logic wr_at(input logic [WIN_BITS-1:0] o);
        return wr_en && (offs == o);
    endfunction

    // Queue base and depth registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqb_q    <= '0;
            cqb_q    <= '0;
            sq_dep_q <= '0;
            cq_dep_q <= '0;
        end else begin
            if (wr_at(OFS_SQB_LO)) sqb_q[31:0]  <= wr_data;
            if (wr_at(OFS_SQB_HI)) sqb_q[63:32] <= wr_data;
            if (wr_at(OFS_CQB_LO)) cqb_q[31:0]  <= wr_data;
            if (wr_at(OFS_CQB_HI)) cqb_q[63:32] <= wr_data;
            if (wr_at(OFS_SQ_DEP)) sq_dep_q     <= wr_data[PTR_W-1:0];
            if (wr_at(OFS_CQ_DEP)) cq_dep_q     <= wr_data[PTR_W-1:0];
        end
    end

    // Queue pointers; soft reset wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_tl_q <= '0;
            cq_hd_q <= '0;
            sq_hd_q <= '0;
        end else if (srst_q) begin
            sq_tl_q <= '0;
            cq_hd_q <= '0;
            sq_hd_q <= '0;
        end else begin
            if (wr_at(OFS_SQ_TL)) sq_tl_q <= wr_data[PTR_W-1:0];
            if (wr_at(OFS_CQ_HD)) cq_hd_q <= wr_data[PTR_W-1:0];
            if (cmpl_ok) sq_hd_q <= (sq_hd_q == sq_dep_q) ? '0 : sq_hd_q + 1'b1;
        end
    end

    // Control bits; the reset request lives for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            pause_q <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            if (wr_at(OFS_CTL_A)) begin
                en_q    <= wr_data[BIT_EN];
                pause_q <= wr_data[BIT_PAUSE];
            end
            srst_q <= wr_at(OFS_CTL_B) && wr_data[BIT_SRST];
        end
    end

    always_comb begin
        ist_set = '0;
        ist_set[BIT_IST_OK]  = cmpl_ok && eng_lirq;
        ist_set[BIT_IST_ERR] = cmpl_err;
        ist_clr = wr_at(OFS_IST) ? wr_data[IRQ_W-1:0] : '0;
    end

    // Interrupt status (write one to clear, set wins) and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ist_q  <= '0;
            imsk_q <= '1;
        end else begin
            ist_q <= (ist_q & ~ist_clr) | ist_set;
            if (wr_at(OFS_IMSK)) imsk_q <= wr_data[IRQ_W-1:0];
        end
    end

    mcd_chan_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .pause    (pause_q),
        .soft_rst (srst_q),
        .pending  (sq_tl_q != sq_hd_q),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .state_o  (state),
        .start_o  (eng_start),
        .hold_o   (eng_hold),
        .cmpl_ok  (cmpl_ok),
        .cmpl_err (cmpl_err)
    );

    // Read-back multiplexer
    always_comb begin
        unique case (offs)
            OFS_SQB_LO: rd_val = sqb_q[31:0];
            OFS_SQB_HI: rd_val = sqb_q[63:32];
            OFS_SQ_DEP: rd_val = {{PAD_P{1'b0}}, sq_dep_q};
            OFS_SQ_TL:  rd_val = {{PAD_P{1'b0}}, sq_tl_q};
            OFS_CQB_LO: rd_val = cqb_q[31:0];
            OFS_CQB_HI: rd_val = cqb_q[63:32];
            OFS_CQ_DEP: rd_val = {{PAD_P{1'b0}}, cq_dep_q};
            OFS_CQ_HD:  rd_val = {{PAD_P{1'b0}}, cq_hd_q};
            OFS_CTL_A:  rd_val = 32'((pause_q << BIT_PAUSE) | (en_q << BIT_EN));
            OFS_CTL_B:  rd_val = 32'(srst_q << BIT_SRST);
            OFS_STATE:  rd_val = {28'd0, state};
            OFS_IST:    rd_val = {{PAD_I{1'b0}}, ist_q};
            OFS_IMSK:   rd_val = {{PAD_I{1'b0}}, imsk_q};
            default:    rd_val = '0;
        endcase
    end

    assign sq_idx  = sq_hd_q;
    assign sq_base = sqb_q;
    assign irq     = |(ist_q & ~imsk_q);

    // R9: an applied reset leaves buffer-clear with zero pointers
    p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (state == 4'd7 && sq_tl_q == '0 && cq_hd_q == '0 && sq_hd_q == '0));
    // R9: the reset request clears itself unless written again
    p_srst_selfclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !wr_at(OFS_CTL_B)) |=> !srst_q);
    // R11: an error completion always leaves status bit 1 set
    p_err_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_err |=> ist_q[BIT_IST_ERR]);
    // R12: a fully masked channel never interrupts
    p_masked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (imsk_q == '1) |-> !irq);
endmodule

// File: rtl/mcd_chan_ctl.sv
// Top of the multi-channel DMA queue control block. Decodes the register
// bus into per-channel windows, replicates the channel logic NUM_CH times
// and registers the read data. Assumes one bus access per cycle at most
// per direction; read data appears after the edge that samples bus_re.
module mcd_chan_ctl
    import mcd_pkg::*;
#(
    parameter  int NUM_CH  = 4,
    parameter  int PTR_W   = 10,
    localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = WIN_BITS + CH_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic                    bus_re,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NUM_CH-1:0]       eng_start,
    output logic [NUM_CH-1:0]       eng_hold,
    output logic [NUM_CH*PTR_W-1:0] eng_sq_idx,
    output logic [NUM_CH*64-1:0]    eng_sq_base,
    input  logic [NUM_CH-1:0]       eng_done,
    input  logic [NUM_CH-1:0]       eng_err,
    input  logic [NUM_CH-1:0]       eng_lirq,
    output logic [NUM_CH-1:0]       irq
);
    logic [NUM_CH-1:0]   ch_we;
    logic [WIN_BITS-1:0] offs;
    logic [CH_BITS-1:0]  ch_num;
    logic                hit;
    logic [31:0]         ch_rd [NUM_CH];

    mcd_addr_dec #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .ch_we  (ch_we),
        .offs   (offs),
        .ch_num (ch_num),
        .hit    (hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mcd_chan_regs #(.PTR_W(PTR_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ch_we[g]),
            .offs      (offs),
            .wr_data   (bus_wdata),
            .rd_val    (ch_rd[g]),
            .eng_done  (eng_done[g]),
            .eng_err   (eng_err[g]),
            .eng_lirq  (eng_lirq[g]),
            .eng_start (eng_start[g]),
            .eng_hold  (eng_hold[g]),
            .sq_idx    (eng_sq_idx[g*PTR_W +: PTR_W]),
            .sq_base   (eng_sq_base[g*64 +: 64]),
            .irq       (irq[g])
        );
    end

    // Registered read data from the addressed window
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= hit ? ch_rd[ch_num] : '0;
    end

    // R1: read data only changes at an edge that sampled a read strobe
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/tb_mcd_chan_ctl.sv
`timescale 1ns/100ps
module tb_mcd_chan_ctl;
    localparam int NC = 4;
    localparam int PW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0, bus_re = 1'b0;
    logic [9:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   eng_start, eng_hold, irq;
    logic [NC*PW-1:0] eng_sq_idx;
    logic [NC*64-1:0] eng_sq_base;
    logic [NC-1:0]   eng_done = '0, eng_err = '0, eng_lirq = '0;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mcd_chan_ctl #(.NUM_CH(NC), .PTR_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_hold(eng_hold), .eng_sq_idx(eng_sq_idx),
        .eng_sq_base(eng_sq_base), .eng_done(eng_done), .eng_err(eng_err),
        .eng_lirq(eng_lirq), .irq(irq)
    );

    function automatic logic [9:0] ad(input int ch, input logic [7:0] off);
        return {2'(ch), off};
    endfunction

    // Expected read-back of a written queue register (R2)
    function automatic logic [31:0] exp_rb(input logic [7:0] off, input logic [31:0] v);
        return (off == 8'h18 || off == 8'h1C || off == 8'h08) ? (v & 32'h3FF) : v;
    endfunction

    function automatic int nxt(input int p, input int dep);
        return (p == dep) ? 0 : p + 1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [PW-1:0] idx(input int ch);
        return eng_sq_idx[ch*PW +: PW];
    endfunction

    task automatic pulse_done(input int ch, input logic e, input logic l);
        eng_done[ch] = 1'b1; eng_err[ch] = e; eng_lirq[ch] = l;
        @(negedge clk);
        eng_done[ch] = 1'b0; eng_err[ch] = 1'b0; eng_lirq[ch] = 1'b0;
    endtask

    // Wait for a start, check the index, then finish the descriptor
    task automatic run_one(input int ch, input logic l, input int exp_idx, input int dly);
        for (int i = 0; i < 8; i++) if (!eng_start[ch]) @(negedge clk);
        chk("R4 start seen", eng_start[ch], 1'b1);
        chk("R4 start index", idx(ch), PW'(exp_idx));
        tick(dly);
        pulse_done(ch, 1'b0, l);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h, t, seed;
        logic [7:0] offl [6];
        offl = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C};
        seed = $urandom(32'h5EED1234);
        tick(4);
        rst_n = 1'b1;

        // Reset state
        rd(ad(0, 8'h30), d); chk("R10 reset state idle", d, 0);
        rd(ad(2, 8'h44), d); chk("R12 mask resets to all ones", d, 32'h1FFF);
        rd(ad(0, 8'h20), d); chk("R3 control resets to zero", d, 0);
        chk("R12 no irq after reset", irq, 0);

        // Register decode and read-back
        wr(ad(3, 8'h00), 32'hDEADBEEF);
        rd(ad(3, 8'h00), d); chk("R2 sq base low readback", d, 32'hDEADBEEF);
        rd(ad(2, 8'h00), d); chk("R13 other channel untouched", d, 0);
        rd(ad(3, 8'h28), d); chk("R1 unmapped offset reads zero", d, 0);
        wr(ad(1, 8'h08), 32'hFFFFFFFF);
        rd(ad(1, 8'h08), d); chk("R2 depth holds PTR_W bits", d, 32'h3FF);
        chk("R2 base reaches engine", eng_sq_base[3*64 +: 32], 32'hDEADBEEF);

        // Channel 0: paused idle never starts, then start
        wr(ad(0, 8'h08), 3);
        wr(ad(0, 8'h44), 0);
        wr(ad(0, 8'h20), 32'h11);
        rd(ad(0, 8'h20), d); chk("R3 enable and pause readback", d, 32'h11);
        wr(ad(0, 8'h0C), 1);
        tick(2);
        chk("R7 paused idle no start", eng_start[0], 0);
        rd(ad(0, 8'h30), d); chk("R7 paused idle stays idle", d, 0);
        wr(ad(0, 8'h20), 32'h01);
        chk("R4 no start before next edge", eng_start[0], 0);
        @(negedge clk);
        chk("R4 start pulse", eng_start[0], 1);
        chk("R4 start index zero", idx(0), 0);
        @(negedge clk);
        chk("R4 start lasts one cycle", eng_start[0], 0);

        // Pause and resume a running channel
        wr(ad(0, 8'h20), 32'h11);
        tick(1);
        chk("R7 hold while paused", eng_hold[0], 1);
        rd(ad(0, 8'h30), d); chk("R7 pause state code", d, 3);
        wr(ad(0, 8'h20), 32'h01);
        tick(1);
        chk("R7 hold released", eng_hold[0], 0);
        rd(ad(0, 8'h30), d); chk("R7 resumed run", d, 1);

        // Successful completion with local interrupt
        pulse_done(0, 1'b0, 1'b1);
        rd(ad(0, 8'h30), d); chk("R5 complete state code", d, 2);
        chk("R12 irq when unmasked", irq[0], 1);
        chk("R5 head advanced", idx(0), 1);
        rd(ad(0, 8'h40), d); chk("R11 done status bit 0", d, 1);
        rd(ad(0, 8'h30), d); chk("R5 back to idle", d, 0);
        wr(ad(0, 8'h40), 1);
        chk("R11 write one clears", irq[0], 0);
        rd(ad(0, 8'h40), d); chk("R11 status cleared", d, 0);

        // Wrap at depth value 3
        wr(ad(0, 8'h0C), 3);
        run_one(0, 1'b0, 1, 0);
        run_one(0, 1'b0, 2, 1);
        tick(2);
        wr(ad(0, 8'h0C), 0);
        run_one(0, 1'b1, 3, 0);
        chk("R5 head wraps to zero", idx(0), 0);
        tick(2);
        rd(ad(0, 8'h30), d); chk("R5 idle after wrap", d, 0);
        wr(ad(0, 8'h40), 32'h1FFF);

        // Channel 1: error and abort, then soft reset
        wr(ad(1, 8'h44), 0);
        wr(ad(1, 8'h1C), 32'h55);
        wr(ad(1, 8'h20), 1);
        wr(ad(1, 8'h0C), 1);
        tick(1);
        chk("R4 channel 1 started", eng_start[1], 1);
        pulse_done(1, 1'b1, 1'b0);
        rd(ad(1, 8'h30), d); chk("R6 abort state code", d, 5);
        tick(3);
        rd(ad(1, 8'h30), d); chk("R6 abort is sticky", d, 5);
        chk("R6 head not advanced", idx(1), 0);
        rd(ad(1, 8'h40), d); chk("R11 error status bit 1", d, 2);
        chk("R12 error raises irq", irq[1], 1);
        wr(ad(1, 8'h24), 1);
        rd(ad(1, 8'h24), d); chk("R9 reset bit reads one", d, 1);
        rd(ad(1, 8'h30), d); chk("R9 buffer-clear code", d, 7);
        rd(ad(1, 8'h0C), d); chk("R9 tail zeroed", d, 0);
        rd(ad(1, 8'h30), d); chk("R9 idle after reset", d, 0);
        rd(ad(1, 8'h1C), d); chk("R9 completion head zeroed", d, 0);
        rd(ad(1, 8'h24), d); chk("R9 reset bit self-clears", d, 0);
        chk("R9 head zeroed", idx(1), 0);
        rd(ad(0, 8'h0C), d); chk("R13 channel 0 tail kept", d, 0);
        wr(ad(1, 8'h40), 32'h1FFF);

        // Channel 2: disable while running, masked interrupt
        wr(ad(2, 8'h08), 7);
        wr(ad(2, 8'h20), 1);
        wr(ad(2, 8'h0C), 1);
        tick(1);
        chk("R4 channel 2 started", eng_start[2], 1);
        wr(ad(2, 8'h20), 0);
        tick(1);
        rd(ad(2, 8'h30), d); chk("R8 wait state code", d, 6);
        pulse_done(2, 1'b0, 1'b1);
        rd(ad(2, 8'h30), d); chk("R8 halt state code", d, 4);
        rd(ad(2, 8'h30), d); chk("R8 idle after halt", d, 0);
        chk("R8 head advanced", idx(2), 1);
        chk("R12 masked status no irq", irq[2], 0);
        rd(ad(2, 8'h40), d); chk("R11 status set under mask", d, 1);

        // Random register traffic on channel 3
        for (int i = 0; i < 60; i++) begin
            logic [7:0]  o;
            logic [31:0] v;
            o = offl[$urandom_range(0, 5)];
            v = $urandom;
            wr(ad(3, o), v);
            rd(ad(3, o), d);
            chk("R2 random readback", d, exp_rb(o, v));
        end

        // Random descriptor runs on channel 3, depth value 3
        wr(ad(3, 8'h1C), 0);
        wr(ad(3, 8'h08), 3);
        wr(ad(3, 8'h44), 0);
        wr(ad(3, 8'h20), 1);
        h = 0; t = 0;
        for (int i = 0; i < 40; i++) begin
            logic l;
            l = 1'($urandom_range(0, 1));
            t = nxt(t, 3);
            wr(ad(3, 8'h0C), 32'(t));
            run_one(3, l, h, $urandom_range(0, 3));
            h = nxt(h, 3);
            chk("R5 random head advance", idx(3), PW'(h));
            chk("R12 random irq follows flag", irq[3], l);
            rd(ad(3, 8'h40), d); chk("R11 random status", d, 32'(l));
            wr(ad(3, 8'h40), 1);
            tick(1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule